// File: doc/BRIEF.md
# Circular-Buffer DMA Address Generator

This block produces the system-memory byte address for one bus-master DMA channel that moves data through a circular buffer. Software sets a buffer start address, a buffer size in bytes and an interrupt interval in bytes. It then starts the channel through a control write. The engine that moves the data reports each completed beat together with its byte count. For each beat the block moves its address pointer forward and reduces its remaining-byte count by that amount.

When the remaining count runs out, the block does one of two things. With looping on, it returns the pointer to the buffer start, reloads the count and sets a sticky wrap flag. With looping off, it turns itself off. A second counter runs on its own, independent of the buffer edges. It requests a one-cycle interrupt each time the programmed number of bytes has gone by, and then reloads.

Top module: `circ_dma_addr_gen`

## Requirements
- R1: After reset, every stored register and every output is zero. This includes the current address, both counts, enable, loop, the wrap flag and the interrupt request.
- R2: A configuration write with select 0 loads the buffer start address, select 1 loads the buffer size (low 24 bits) and select 2 loads the interrupt interval (low 24 bits). None of these writes changes the current address, the current count or the interrupt count.
- R3: A select-3 control write uses bit 0 as enable, bit 1 as loop and bit 2 as the wrap-flag clear. If enable was 0 before the write and bit 0 is 1, then on the next cycle the current address holds the start address, the current count holds the size and the interrupt count holds the interval.
- R4: A beat of N bytes, taken while enabled with N smaller than the current count, adds N to the current address and subtracts N from the current count.
- R5: A beat with N at or above the current count, taken while looping is on, reloads the address and count from the start address and size, sets the wrap flag and leaves the channel enabled.
- R6: The same end-of-buffer beat taken with looping off clears enable. It adds N to the address, sets the count to 0 and leaves the wrap flag unchanged.
- R7: Beats presented while enable is 0 change no address, count or flag.
- R8: A beat taken while enabled with N at or above the interrupt count raises the interrupt request for exactly the next cycle and reloads the interrupt count from the interval. Any other beat taken while enabled subtracts N from the interrupt count.
- R9: A control write with bit 2 set clears the wrap flag. If a wrap happens in the same cycle, the flag stays set.
- R10: When a control write and a beat arrive in the same cycle, the beat is handled using the enable and loop values from before the write. Enable and loop then take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 start address, 1 size, 2 interrupt interval, 3 control |
| cfgWrData | input | 32 | Write data |
| beatValid | input | 1 | A beat completed this cycle |
| beatBytes | input | 4 | Bytes moved by the beat |
| curAddr | output | 32 | Current byte address |
| curCount | output | 24 | Bytes left before the buffer end |
| irqCount | output | 24 | Bytes left before the next interrupt |
| chanEnable | output | 1 | Channel running |
| loopEnable | output | 1 | Wrap at buffer end instead of stopping |
| wrapStatus | output | 1 | Sticky wrap flag |
| irqReq | output | 1 | One-cycle interrupt request |

## Verification
The hardest case to reach is a wrap that lands in the same cycle as a write that clears the wrap flag. The beat must arrive exactly when the remaining count is used up, while a control write that keeps the channel running carries the clear bit. The stimulus sizes its beats so the buffer runs out on a known cycle and places the control write on that cycle. It also places a control write that turns the channel off on the same cycle as a beat, to show that the old enable still governs that beat.

// File: rtl/circ_dma_pkg.sv
package circ_dma_pkg;
  localparam logic [1:0] SEL_BASE_ADDR = 2'd0;
  localparam logic [1:0] SEL_BASE_CNT  = 2'd1;
  localparam logic [1:0] SEL_IRQ_BASE  = 2'd2;
  localparam logic [1:0] SEL_CTRL      = 2'd3;

  typedef struct packed {
    logic loadBaseAddr;
    logic loadBaseCount;
    logic loadIrqBase;
    logic start;
    logic advance;
    logic wrap;
    logic stop;
    logic irqDown;
    logic irqReload;
  } dmaStrobes_t;
endpackage

// File: rtl/circ_dma_ctrl.sv
module circ_dma_ctrl
  import circ_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgSel,
  input  logic [2:0]  ctrlBits,
  input  logic        beatValid,
  input  logic        endHit,
  input  logic        irqHit,
  output dmaStrobes_t strobes,
  output logic        chanEnable,
  output logic        loopEnable,
  output logic        wrapStatus,
  output logic        irqReq
);
  logic ctrlWr;
  logic beatGo;

  always_comb begin
    ctrlWr = cfgWrEn && (cfgSel == SEL_CTRL);
    beatGo = beatValid && chanEnable;
    strobes.loadBaseAddr  = cfgWrEn && (cfgSel == SEL_BASE_ADDR);
    strobes.loadBaseCount = cfgWrEn && (cfgSel == SEL_BASE_CNT);
    strobes.loadIrqBase   = cfgWrEn && (cfgSel == SEL_IRQ_BASE);
    strobes.start         = ctrlWr && ctrlBits[0] && !chanEnable;
    strobes.advance       = beatGo && !endHit;
    strobes.wrap          = beatGo && endHit && loopEnable;
    strobes.stop          = beatGo && endHit && !loopEnable;
    strobes.irqDown       = beatGo && !irqHit;
    strobes.irqReload     = beatGo && irqHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEnable <= 1'b0;
      loopEnable <= 1'b0;
      wrapStatus <= 1'b0;
      irqReq     <= 1'b0;
    end else begin
      if (ctrlWr) begin
        chanEnable <= ctrlBits[0];
        loopEnable <= ctrlBits[1];
      end else if (strobes.stop) begin
        chanEnable <= 1'b0;
      end
      if (strobes.wrap)
        wrapStatus <= 1'b1;
      else if (ctrlWr && ctrlBits[2])
        wrapStatus <= 1'b0;
      irqReq <= strobes.irqReload;
    end
  end
endmodule

// File: rtl/circ_dma_datapath.sv
module circ_dma_datapath
  import circ_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [BEAT_W-1:0] beatBytes,
  output logic              endHit,
  output logic              irqHit,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  curCount,
  output logic [CNT_W-1:0]  irqCount
);
  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  baseCount;
  logic [CNT_W-1:0]  irqBase;
  logic [CNT_W-1:0]  stepCnt;
  logic [ADDR_W-1:0] stepAddr;

  assign stepCnt  = CNT_W'(beatBytes);
  assign stepAddr = ADDR_W'(beatBytes);
  assign endHit   = stepCnt >= curCount;
  assign irqHit   = stepCnt >= irqCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr  <= '0;
      baseCount <= '0;
      irqBase   <= '0;
      curAddr   <= '0;
      curCount  <= '0;
      irqCount  <= '0;
    end else begin
      if (strobes.loadBaseAddr)  baseAddr  <= wrData;
      if (strobes.loadBaseCount) baseCount <= wrData[CNT_W-1:0];
      if (strobes.loadIrqBase)   irqBase   <= wrData[CNT_W-1:0];

      if (strobes.start || strobes.wrap) begin
        curAddr  <= baseAddr;
        curCount <= baseCount;
      end else if (strobes.advance) begin
        curAddr  <= curAddr + stepAddr;
        curCount <= curCount - stepCnt;
      end else if (strobes.stop) begin
        curAddr  <= curAddr + stepAddr;
        curCount <= '0;
      end

      if (strobes.start || strobes.irqReload)
        irqCount <= irqBase;
      else if (strobes.irqDown)
        irqCount <= irqCount - stepCnt;
    end
  end
endmodule

// File: rtl/circ_dma_addr_gen.sv
module circ_dma_addr_gen
  import circ_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              beatValid,
  input  logic [BEAT_W-1:0] beatBytes,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  curCount,
  output logic [CNT_W-1:0]  irqCount,
  output logic              chanEnable,
  output logic              loopEnable,
  output logic              wrapStatus,
  output logic              irqReq
);
  dmaStrobes_t strobes;
  logic endHit;
  logic irqHit;

  circ_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .ctrlBits(cfgWrData[2:0]), .beatValid(beatValid), .endHit(endHit),
    .irqHit(irqHit), .strobes(strobes), .chanEnable(chanEnable),
    .loopEnable(loopEnable), .wrapStatus(wrapStatus), .irqReq(irqReq)
  );

  circ_dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(cfgWrData),
    .beatBytes(beatBytes), .endHit(endHit), .irqHit(irqHit),
    .curAddr(curAddr), .curCount(curCount), .irqCount(irqCount)
  );
endmodule

// File: rtl/circ_dma_checker.sv
module circ_dma_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [1:0]        cfgSel,
  input logic [ADDR_W-1:0] cfgWrData,
  input logic              beatValid,
  input logic [BEAT_W-1:0] beatBytes,
  input logic [ADDR_W-1:0] curAddr,
  input logic [CNT_W-1:0]  curCount,
  input logic [CNT_W-1:0]  irqCount,
  input logic              chanEnable,
  input logic              loopEnable,
  input logic              wrapStatus,
  input logic              irqReq
);
  logic runBeat;
  assign runBeat = chanEnable && beatValid && !cfgWrEn;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEnable && !cfgWrEn) |=> ($stable(curAddr) && $stable(curCount))); // R7

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (runBeat && (CNT_W'(beatBytes) < curCount))
      |=> (curCount == $past(curCount) - CNT_W'($past(beatBytes)))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (runBeat && (CNT_W'(beatBytes) < curCount))
      |=> (curAddr == $past(curAddr) + ADDR_W'($past(beatBytes)))); // R4

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (runBeat && !loopEnable && (CNT_W'(beatBytes) >= curCount))
      |=> (!chanEnable && curCount == '0)); // R6

  AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable && beatValid && loopEnable && (CNT_W'(beatBytes) >= curCount))
      |=> wrapStatus); // R5

  AST_WRAP_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (wrapStatus && !(cfgWrEn && cfgSel == 2'd3 && cfgWrData[2])) |=> wrapStatus); // R9

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rstN)
    !(chanEnable && beatValid) |=> !irqReq); // R8
endmodule

bind circ_dma_addr_gen circ_dma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
  .beatValid(beatValid), .beatBytes(beatBytes), .curAddr(curAddr), .curCount(curCount),
  .irqCount(irqCount), .chanEnable(chanEnable), .loopEnable(loopEnable),
  .wrapStatus(wrapStatus), .irqReq(irqReq)
);

// File: tb/tb_circ_dma_addr_gen.sv
module tb_circ_dma_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgSel;
  logic [31:0] cfgWrData;
  logic        beatValid;
  logic [3:0]  beatBytes;
  logic [31:0] curAddr;
  logic [23:0] curCount;
  logic [23:0] irqCount;
  logic        chanEnable, loopEnable, wrapStatus, irqReq;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // behavioural reference state
  longint mBaseA = 0, mBaseC = 0, mIrqB = 0, mA = 0, mC = 0, mI = 0;
  bit mEn = 0, mLoop = 0, mWrap = 0, mIrq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_dma_addr_gen dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .beatValid(beatValid), .beatBytes(beatBytes), .curAddr(curAddr), .curCount(curCount),
    .irqCount(irqCount), .chanEnable(chanEnable), .loopEnable(loopEnable),
    .wrapStatus(wrapStatus), .irqReq(irqReq)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mBaseA = 0; mBaseC = 0; mIrqB = 0; mA = 0; mC = 0; mI = 0;
      mEn = 0; mLoop = 0; mWrap = 0; mIrq = 0;
    end else begin
      bit oldEn, oldLoop, took, ended, hit;
      int n;
      oldEn = mEn; oldLoop = mLoop; n = beatBytes;
      took = beatValid && oldEn;
      ended = took && (n >= mC);
      hit = took && (n >= mI);
      mIrq = hit;
      if (took) begin
        if (!ended) begin mA = (mA + n) % 64'h1_0000_0000; mC = mC - n; end
        else if (oldLoop) begin mA = mBaseA; mC = mBaseC; mWrap = 1; end
        else begin mA = (mA + n) % 64'h1_0000_0000; mC = 0; mEn = 0; end
        mI = hit ? mIrqB : mI - n;
      end
      if (cfgWrEn) begin
        case (cfgSel)
          2'd0: mBaseA = cfgWrData;
          2'd1: mBaseC = cfgWrData & 32'hFF_FFFF;
          2'd2: mIrqB  = cfgWrData & 32'hFF_FFFF;
          default: begin
            if (cfgWrData[0] && !oldEn) begin mA = mBaseA; mC = mBaseC; mI = mIrqB; end
            mEn = cfgWrData[0];
            mLoop = cfgWrData[1];
            if (cfgWrData[2] && !(took && ended && oldLoop)) mWrap = 0;
          end
        endcase
      end
    end
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("curAddr", curAddr, mA);
    chk("curCount", curCount, mC);
    chk("irqCount", irqCount, mI);
    chk("chanEnable", chanEnable, mEn);
    chk("loopEnable", loopEnable, mLoop);
    chk("wrapStatus", wrapStatus, mWrap);
    chk("irqReq", irqReq, mIrq);
  endtask

  task automatic step(bit we, logic [1:0] sel, logic [31:0] d, bit bv, logic [3:0] nb);
    cfgWrEn = we; cfgSel = sel; cfgWrData = d; beatValid = bv; beatBytes = nb;
    @(posedge clk); #1;
    compareAll();
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0); endtask
  task automatic beat(logic [3:0] nb); step(0, 0, 0, 1, nb); endtask
  task automatic wr(logic [1:0] sel, logic [31:0] d); step(1, sel, d, 0, 0); endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    rstN = 0; cfgWrEn = 0; cfgSel = 0; cfgWrData = 0; beatValid = 0; beatBytes = 0;
    repeat (3) @(posedge clk);
    #1;
    curReq = "R1"; compareAll();
    rstN = 1;

    curReq = "R2";
    wr(2'd0, 32'h0000_1000);
    wr(2'd1, 32'hAB00_0010);
    wr(2'd2, 32'h0000_000C);
    chk("R2 current address untouched", curAddr, 0);

    curReq = "R7";
    beat(4); beat(8);
    chk("R7 idle beat count", curCount, 0);

    curReq = "R3";
    wr(2'd3, 32'h3);
    chk("R3 start address", curAddr, 32'h1000);
    chk("R3 start count", curCount, 16);

    curReq = "R4";
    beat(4); idle(); beat(4);
    chk("R4 stepped address", curAddr, 32'h1008);
    curReq = "R8";
    beat(4);
    chk("R8 interrupt pulse", irqReq, 1);
    idle();
    chk("R8 pulse one cycle", irqReq, 0);

    curReq = "R9";
    step(1, 2'd3, 32'h7, 1, 4);
    chk("R9 wrap beats clear", wrapStatus, 1);
    curReq = "R5";
    chk("R5 reload address", curAddr, 32'h1000);
    curReq = "R9";
    wr(2'd3, 32'h7);
    chk("R9 clear alone", wrapStatus, 0);

    curReq = "R4";
    beat(1); beat(3); beat(8); idle(); beat(2); beat(5);
    curReq = "R5";
    beat(15); beat(8); beat(8);

    curReq = "R10";
    step(1, 2'd3, 32'h0, 1, 3);
    chk("R10 beat taken then disabled", chanEnable, 0);
    beat(4);

    curReq = "R6";
    wr(2'd1, 32'd10);
    wr(2'd2, 32'd6);
    wr(2'd3, 32'h1);
    beat(4); beat(4); beat(4);
    chk("R6 stopped", chanEnable, 0);
    chk("R6 count zero", curCount, 0);
    beat(4); idle();

    curReq = "R1";
    rstN = 0; idle(); rstN = 1;
    chk("R1 reset again", curAddr, 0);
    idle();
    finishRun();
  end
endmodule